// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast input clock by a programmable whole ratio and emits one comparison pulse per completed division cycle, as the feedback path of a frequency synthesizer would. It is built from a digital model of a dual-modulus prescaler, a main counter and a swallow counter. During one division cycle the prescaler divides by P+1 for the first A prescaler periods and by P for the remaining N-A periods, so the whole cycle lasts P*N+A input clocks.

The prescaler base P is picked at run time by a select input: P = 2^P_LOG2 when the select is high and P = 2^(P_LOG2+1) when it is low. With the default P_LOG2 of 4, these are 16 and 32. A value of 6 gives the 64/128 pair of a high-band instance. The N and A words come from a configuration latch outside the block. They are sampled only at cycle boundaries. Illegal words are clamped and flagged. An active-low power-save input stops all counting. Releasing it restarts the divider from a freshly loaded state.

Top module: `swallow_fb_divider`

## Requirements
- R1: With legal settings, consecutive comparison pulses are exactly P*N+A input clocks apart. P is 2^P_LOG2 when mod_sel is 1 and 2^(P_LOG2+1) when mod_sel is 0; with the default P_LOG2 = 4 these are 16 and 32. This holds for A = 0 and for A = N-1 alike.
- R2: Each comparison pulse is high for exactly one input clock.
- R3: An n_cfg value below 5 is treated as 5.
- R4: An a_cfg value not below the (already raised) N is treated as N-1.
- R5: cfg_err is registered. One clock after a configuration is presented, cfg_err reads 1 if n_cfg < 5 or a_cfg >= n_cfg, and 0 otherwise.
- R6: A change of n_cfg, a_cfg or mod_sel made during a division cycle leaves that cycle's length unchanged. The new ratio applies from the next cycle on.
- R7: While ps_n is 0, no comparison pulse is produced and the counters hold.
- R8: If ps_n is sampled high at clock edge e after being low (or after reset), the block loads the current settings at e. The first pulse then appears in the clock cycle that follows edge e+P*N+A.
- R9: During and right after reset, cmp_pulse and cfg_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps_n | input | 1 | Power save, active low (1 = run) |
| mod_sel | input | 1 | Prescaler base select: 1 = 2^P_LOG2, 0 = 2^(P_LOG2+1) |
| n_cfg | input | 11 | Main count N from the configuration latch |
| a_cfg | input | 7 | Swallow count A from the configuration latch |
| cmp_pulse | output | 1 | One-clock pulse at each division cycle boundary |
| cfg_err | output | 1 | Registered flag for an out-of-range N or A |

## Verification
The period is measured between pulses under several kinds of settings:

- A = 0, which isolates the plain P*N part.
- A = N-1, which exercises the longest swallow phase.
- Both prescaler bases, which separate the two values of P.
- Seeded random legal and illegal words.
- A large N with the maximum A, which exercises the wide counters.

Illegal words (N below 5, A at or above N) tell clamping apart from pass-through by the period they produce. Settings changed just after a pulse show whether the old ratio survives for one more cycle. Power save entered between pulses, and at a pulse, checks that no pulse leaks out and that the restart delay is one full period from the release edge.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    parameter int unsigned SFD_N_W   = 11;
    parameter int unsigned SFD_A_W   = 7;
    parameter int unsigned SFD_N_MIN = 5;
    parameter int unsigned SFD_P_LOG2 = 4;
endpackage

// File: rtl/sfd_cfg_clamp.sv
// Forces the configuration words into the legal range and reports misuse.
module sfd_cfg_clamp #(
    parameter int unsigned N_W   = sfd_pkg::SFD_N_W,
    parameter int unsigned A_W   = sfd_pkg::SFD_A_W,
    parameter int unsigned N_MIN = sfd_pkg::SFD_N_MIN
) (
    input  logic [N_W-1:0] n_raw,
    input  logic [A_W-1:0] a_raw,
    output logic [N_W-1:0] n_ok,
    output logic [A_W-1:0] a_ok,
    output logic           bad
);
    localparam int unsigned CW = (N_W > A_W) ? N_W : A_W;
    localparam logic [N_W-1:0] NMIN_V = N_W'(N_MIN);

    logic           n_low;
    logic [CW-1:0]  n_x;
    logic [CW-1:0]  nt_x;
    logic [CW-1:0]  a_x;
    logic           a_big;

    always_comb begin
        n_low = (n_raw < NMIN_V);
        n_ok  = n_low ? NMIN_V : n_raw;
        n_x   = CW'(n_raw);
        nt_x  = CW'(n_ok);
        a_x   = CW'(a_raw);
        a_big = (a_x >= nt_x);
        a_ok  = a_big ? A_W'(nt_x - CW'(1)) : a_raw;
        bad   = n_low || (a_x >= n_x);
    end
endmodule

// File: rtl/sfd_prescaler.sv
// Digital model of the dual-modulus prescaler: counts one modulus period
// and raises tick on its last input clock.
module sfd_prescaler #(
    parameter int unsigned MW = sfd_pkg::SFD_P_LOG2 + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          load,
    input  logic [MW-1:0] load_mod,
    input  logic [MW-1:0] next_mod,
    output logic          tick
);
    typedef struct packed {
        logic [MW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = active && (pre_q.cnt == '0);
        if (load) begin
            pre_d.cnt = load_mod - MW'(1);
        end else if (active) begin
            pre_d.cnt = (pre_q.cnt == '0) ? (next_mod - MW'(1)) : (pre_q.cnt - MW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/sfd_cycle_ctrl.sv
// Main and swallow counters, shadow of the ratio, restart and pulse logic.
module sfd_cycle_ctrl #(
    parameter int unsigned N_W    = sfd_pkg::SFD_N_W,
    parameter int unsigned A_W    = sfd_pkg::SFD_A_W,
    parameter int unsigned P_LOG2 = sfd_pkg::SFD_P_LOG2,
    parameter int unsigned MW     = P_LOG2 + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tick,
    input  logic [N_W-1:0] n_ok,
    input  logic [A_W-1:0] a_ok,
    input  logic           sel_in,
    output logic           active,
    output logic           load,
    output logic [MW-1:0]  load_mod,
    output logic [MW-1:0]  next_mod,
    output logic           pulse
);
    localparam logic [MW-1:0] P_FAST = MW'(1) << P_LOG2;
    localparam logic [MW-1:0] P_SLOW = MW'(1) << (P_LOG2 + 1);

    typedef struct packed {
        logic [N_W-1:0] main;
        logic [A_W-1:0] swal;
        logic           sel;
        logic           idle;
        logic           pulse;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic           wrap;
    logic [A_W-1:0] swal_nx;

    function automatic logic [MW-1:0] modulus(input logic sel, input logic extra);
        logic [MW-1:0] base;
        base = sel ? P_FAST : P_SLOW;
        return base + MW'(extra);
    endfunction

    always_comb begin
        active   = run && !ctl_q.idle;
        wrap     = tick && (ctl_q.main == N_W'(1));
        load     = run && (ctl_q.idle || wrap);
        load_mod = modulus(sel_in, a_ok != '0);
        swal_nx  = (ctl_q.swal != '0) ? (ctl_q.swal - A_W'(1)) : '0;
        next_mod = modulus(ctl_q.sel, swal_nx != '0);

        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        if (!run) begin
            ctl_d.idle = 1'b1;
        end else if (load) begin
            ctl_d.main  = n_ok;
            ctl_d.swal  = a_ok;
            ctl_d.sel   = sel_in;
            ctl_d.idle  = 1'b0;
            ctl_d.pulse = wrap;
        end else if (tick) begin
            ctl_d.main = ctl_q.main - N_W'(1);
            ctl_d.swal = swal_nx;
        end
        pulse = ctl_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{main: '0, swal: '0, sel: 1'b1, idle: 1'b1, pulse: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider #(
    parameter int unsigned P_LOG2 = sfd_pkg::SFD_P_LOG2,
    parameter int unsigned N_W    = sfd_pkg::SFD_N_W,
    parameter int unsigned A_W    = sfd_pkg::SFD_A_W,
    parameter int unsigned N_MIN  = sfd_pkg::SFD_N_MIN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ps_n,
    input  logic           mod_sel,
    input  logic [N_W-1:0] n_cfg,
    input  logic [A_W-1:0] a_cfg,
    output logic           cmp_pulse,
    output logic           cfg_err
);
    localparam int unsigned MW = P_LOG2 + 2;

    typedef struct packed {
        logic err;
    } top_t;

    top_t top_d, top_q;

    logic [N_W-1:0] n_ok;
    logic [A_W-1:0] a_ok;
    logic           bad;
    logic           active;
    logic           load;
    logic           tick;
    logic [MW-1:0]  load_mod;
    logic [MW-1:0]  next_mod;
    logic           pulse;

    sfd_cfg_clamp #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) u_clamp (
        .n_raw (n_cfg),
        .a_raw (a_cfg),
        .n_ok  (n_ok),
        .a_ok  (a_ok),
        .bad   (bad)
    );

    sfd_prescaler #(.MW(MW)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .load     (load),
        .load_mod (load_mod),
        .next_mod (next_mod),
        .tick     (tick)
    );

    sfd_cycle_ctrl #(.N_W(N_W), .A_W(A_W), .P_LOG2(P_LOG2), .MW(MW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ps_n),
        .tick     (tick),
        .n_ok     (n_ok),
        .a_ok     (a_ok),
        .sel_in   (mod_sel),
        .active   (active),
        .load     (load),
        .load_mod (load_mod),
        .next_mod (next_mod),
        .pulse    (pulse)
    );

    always_comb begin
        top_d     = top_q;
        top_d.err = bad;
        cmp_pulse = pulse;
        cfg_err   = top_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end
endmodule

// File: rtl/swallow_fb_divider_chk.sv
module swallow_fb_divider_chk #(
    parameter int unsigned P_LOG2 = sfd_pkg::SFD_P_LOG2,
    parameter int unsigned N_W    = sfd_pkg::SFD_N_W,
    parameter int unsigned A_W    = sfd_pkg::SFD_A_W,
    parameter int unsigned N_MIN  = sfd_pkg::SFD_N_MIN
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ps_n,
    input logic [N_W-1:0] n_cfg,
    input logic [A_W-1:0] a_cfg,
    input logic           cmp_pulse,
    input logic           cfg_err
);
    localparam int unsigned GW = 16;
    localparam logic [GW-1:0] MIN_T = GW'(N_MIN << P_LOG2);
    localparam logic [N_W-1:0] NMIN_V = N_W'(N_MIN);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (!ps_n) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else if (cmp_pulse) begin
            seen_q <= 1'b1;
            gap_q  <= GW'(1);
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    // R2: the pulse never lasts two clocks
    p_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pulse |=> !cmp_pulse);

    // R7: nothing comes out while power save is active
    p_quiet_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_n |=> !cmp_pulse);

    // R1: two pulses are never closer than the shortest legal period
    p_min_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_pulse && seen_q) |-> (gap_q >= MIN_T));

    // R5: a short main count is flagged one clock later
    p_err_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (n_cfg < NMIN_V) |=> cfg_err);

    // R5: a legal word leaves the flag low one clock later
    p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((n_cfg >= NMIN_V) && (N_W'(a_cfg) < n_cfg)) |=> !cfg_err);

    // R8: a release never produces an immediate pulse
    p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ps_n) |=> !cmp_pulse);
endmodule

bind swallow_fb_divider swallow_fb_divider_chk #(
    .P_LOG2(P_LOG2), .N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ps_n      (ps_n),
    .n_cfg     (n_cfg),
    .a_cfg     (a_cfg),
    .cmp_pulse (cmp_pulse),
    .cfg_err   (cfg_err)
);

// File: tb/tb_swallow_fb_divider.sv
module tb_swallow_fb_divider;
    localparam int LIMIT = 40000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ps_n;
    logic        mod_sel;
    logic [10:0] n_cfg;
    logic [6:0]  a_cfg;
    logic        cmp_pulse;
    logic        cfg_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    swallow_fb_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps_n      (ps_n),
        .mod_sel   (mod_sel),
        .n_cfg     (n_cfg),
        .a_cfg     (a_cfg),
        .cmp_pulse (cmp_pulse),
        .cfg_err   (cfg_err)
    );

    function automatic int p_of(input bit sel);
        return sel ? 16 : 32;
    endfunction

    function automatic int n_fix(input int n);
        return (n < 5) ? 5 : n;
    endfunction

    function automatic int a_fix(input int n, input int a);
        int nn;
        nn = n_fix(n);
        return (a >= nn) ? nn - 1 : a;
    endfunction

    function automatic int t_of(input int n, input int a, input bit sel);
        return p_of(sel) * n_fix(n) + a_fix(n, a);
    endfunction

    function automatic bit err_of(input int n, input int a);
        return (n < 5) || (a >= n);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int n, input int a, input bit sel);
        n_cfg   = 11'(n);
        a_cfg   = 7'(a);
        mod_sel = sel;
    endtask

    task automatic to_pulse(output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!cmp_pulse && c < LIMIT);
    endtask

    // Called on a negedge where the pulse is high; applies a new word.
    task automatic step(input int n, input int a, input bit sel, inout int cur_t, input string tag);
        int c;
        int nt;
        drive(n, a, sel);
        nt = t_of(n, a, sel);
        @(negedge clk);
        c = 1;
        check(cfg_err == err_of(n, a), "R5 flag", int'(cfg_err), int'(err_of(n, a)));
        check(!cmp_pulse, "R2 width", int'(cmp_pulse), 0);
        while (!cmp_pulse && c < LIMIT) begin
            @(negedge clk);
            c++;
        end
        check(c == cur_t, "R6 old ratio kept", c, cur_t);
        to_pulse(c);
        check(c == nt, tag, c, nt);
        cur_t = nt;
    endtask

    initial begin
        int c;
        int cur;
        int hits;
        rst_n = 1'b0;
        ps_n  = 1'b0;
        drive(7, 3, 1'b1);
        repeat (3) @(negedge clk);
        check(!cmp_pulse, "R9 pulse in reset", int'(cmp_pulse), 0);
        check(!cfg_err, "R9 flag in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmp_pulse && !cfg_err, "R9 after reset", int'({cmp_pulse, cfg_err}), 0);

        // first start from power save: R8
        ps_n = 1'b1;
        cur  = t_of(7, 3, 1'b1);
        to_pulse(c);
        check(c == cur + 1, "R8 first pulse", c, cur + 1);
        to_pulse(c);
        check(c == cur, "R1 period 7/3 fast", c, cur);

        step(7, 0, 1'b1, cur, "R1 A zero");
        step(5, 4, 1'b0, cur, "R1 A=N-1 slow base");
        step(3, 0, 1'b1, cur, "R3 short N clamp");
        step(2, 9, 1'b0, cur, "R4 both clamps");
        step(10, 20, 1'b1, cur, "R4 A above N");
        step(12, 12, 1'b0, cur, "R4 A equals N");

        // power save entered at a pulse: R7, then R8
        ps_n = 1'b0;
        hits = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (cmp_pulse) hits++;
        end
        check(hits == 0, "R7 no pulse in save", hits, 0);
        ps_n = 1'b1;
        to_pulse(c);
        check(c == cur + 1, "R8 restart at pulse", c, cur + 1);

        // power save entered mid-cycle with a word change during it
        repeat (50) @(negedge clk);
        ps_n = 1'b0;
        hits = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (i == 100) drive(9, 2, 1'b1);
            if (cmp_pulse) hits++;
        end
        check(hits == 0, "R7 mid-cycle save", hits, 0);
        ps_n = 1'b1;
        cur  = t_of(9, 2, 1'b1);
        to_pulse(c);
        check(c == cur + 1, "R8 restart mid-cycle", c, cur + 1);
        to_pulse(c);
        check(c == cur, "R1 after restart", c, cur);

        // seeded random words, legal and illegal
        void'($urandom(32'd2024));
        for (int k = 0; k < 12; k++) begin
            int rn;
            int ra;
            bit rs;
            rn = int'($urandom_range(40, 1));
            ra = int'($urandom_range(50, 0));
            rs = 1'($urandom_range(1, 0));
            step(rn, ra, rs, cur, "R1 random word");
        end

        // wide counters
        step(300, 127, 1'b0, cur, "R1 large N max A");
        step(6, 1, 1'b1, cur, "R6 back to small");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule